// File: doc/BRIEF.md
# Phase-Aligned Bus Acknowledge Generator

This block produces the active-low data transfer acknowledge for an asynchronous, strobe-driven bus cycle whose target may be a shared memory that is time-sliced with DMA. The memory slot timing is carried by two phase clocks of equal frequency. The second clock lags the first by a quarter period, so one slot walks through four phases, written (first, second): (1,0), (1,1), (0,1), (0,0). A new slot begins when both clocks are low. The address strobe and both phase clocks are resynchronized to the system clock. The block notes the phase in which the strobe first shows up. It then either acknowledges after the normal fixed delay or holds the acknowledge back until the next slot start.

Accesses outside the shared-memory region always get the normal delay. A slow device can hold the acknowledge off with an active-high ready line. A fast override line withdraws the block's output enable so that another agent can drive the acknowledge wire. Once the strobe is removed, the acknowledge is dropped at the next clock edge and the sequencer goes back to waiting.

Top module: `dtack_phase_gen`

## Requirements
- R1: While reset is held and right after it, `dtack_no` is 1, the sequencer is idle, and `dtack_oe_o` is 1 as long as `ovr_ni` is 1.
- R2: The strobe and the phase clocks each pass through `SYNC_STAGES` flops (default 2). Let e1 be the first clock edge that samples `as_ni` low. If `chip_sel_i` is 1 and both phase clocks are low at e1, `dtack_no` goes low at edge e1+1+`NORM_TICKS` (default `NORM_TICKS` = 4), which is `NORM_TICKS` clocks after the synchronized strobe edge.
- R3: If `chip_sel_i` is 0, `dtack_no` goes low at edge e1+1+`NORM_TICKS` whatever the phase clocks show.
- R4: If `chip_sel_i` is 1 and at least one phase clock is high at e1 (both high or mixed), the acknowledge is withheld. Let j be the first edge after e1 that samples both phase clocks low. `dtack_no` then goes low at edge j+1+`NORM_TICKS`.
- R5: `dtack_no` is never driven low at an edge that samples `xrdy_i` low. A held-off acknowledge goes low at the first edge where it is due and `xrdy_i` samples 1.
- R6: `dtack_oe_o` is 0 whenever `ovr_ni` is 0 and 1 whenever `ovr_ni` is 1, with no clock delay.
- R7: `dtack_no` is 1 at the first clock edge that samples `as_ni` high.
- R8: If the strobe is withdrawn before the acknowledge is due, `dtack_no` stays 1, the sequencer returns to idle, and the next access is timed as in R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| as_ni | input | 1 | Address strobe, active low |
| chip_sel_i | input | 1 | Access targets the shared, slot-timed memory |
| c1_i | input | 1 | Leading phase clock |
| c3_i | input | 1 | Lagging phase clock (quarter period behind) |
| xrdy_i | input | 1 | Ready from slow devices, low holds off the acknowledge |
| ovr_ni | input | 1 | Override, active low, releases the acknowledge line |
| dtack_no | output | 1 | Data transfer acknowledge, active low |
| dtack_oe_o | output | 1 | Output enable for the acknowledge driver |

## Verification
The ready hold-off and the expiry of the slot-timing count can land on the same edge. The bench provokes this by pulling `xrdy_i` low before the strobe and raising it only several edges after the acknowledge would normally be due. It expects the falling edge of `dtack_no` exactly at the edge that first samples ready high, and never earlier. Strobe start points are swept across every offset of the slot, so that in-sync, both-high and mixed arrivals are each scored against the slot-start arithmetic.

// File: rtl/dtack_pkg.sv
package dtack_pkg;

    // Sequencer states of the acknowledge generator
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_COUNT = 2'd2,
        ST_ACK   = 2'd3
    } dstate_e;

endpackage

// File: rtl/dtack_sync.sv
// Multi-stage resynchronizer for a vector of asynchronous inputs.
module dtack_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/dtack_phase_cls.sv
// Classifies the synchronized phase pair: a slot starts when both are low.
module dtack_phase_cls (
    input  logic c1_s_i,
    input  logic c3_s_i,
    output logic aligned_o
);

    always_comb begin
        aligned_o = ~c1_s_i & ~c3_s_i;
    end

endmodule

// File: rtl/dtack_fsm.sv
// Acknowledge sequencer: decides sync/out-of-sync, counts the fixed delay,
// and gates the acknowledge with ready and the raw strobe.
module dtack_fsm
    import dtack_pkg::*;
#(
    parameter int NORM_TICKS = 4
) (
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    as_s_i,
    input  logic    as_raw_ni,
    input  logic    chip_sel_i,
    input  logic    aligned_i,
    input  logic    xrdy_i,
    output dstate_e st_o,
    output logic    dtack_no
);

    localparam int CNT_W = ($clog2(NORM_TICKS) < 1) ? 1 : $clog2(NORM_TICKS);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(NORM_TICKS - 2);

    typedef struct packed {
        dstate_e         st;
        logic [CNT_W-1:0] cnt;
        logic            dtack_n;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (as_s_i) begin
                    if (!chip_sel_i || aligned_i) begin
                        r_d.st  = ST_COUNT;
                        r_d.cnt = CNT_LOAD;
                    end else begin
                        r_d.st = ST_ALIGN;
                    end
                end
            end
            ST_ALIGN: begin
                if (!as_s_i) begin
                    r_d.st = ST_IDLE;
                end else if (aligned_i) begin
                    r_d.st  = ST_COUNT;
                    r_d.cnt = CNT_LOAD;
                end
            end
            ST_COUNT: begin
                if (!as_s_i) begin
                    r_d.st = ST_IDLE;
                end else if (r_q.cnt == '0) begin
                    r_d.st = ST_ACK;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_ACK: begin
                if (!as_s_i) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        r_d.dtack_n = !((r_d.st == ST_ACK) && xrdy_i && !as_raw_ni);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: ST_IDLE, cnt: '0, dtack_n: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign st_o     = r_q.st;
    assign dtack_no = r_q.dtack_n;

endmodule

// File: rtl/dtack_phase_gen.sv
module dtack_phase_gen
    import dtack_pkg::*;
#(
    parameter int NORM_TICKS  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic as_ni,
    input  logic chip_sel_i,
    input  logic c1_i,
    input  logic c3_i,
    input  logic xrdy_i,
    input  logic ovr_ni,
    output logic dtack_no,
    output logic dtack_oe_o
);

    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] raw_vec, syn_vec;
    logic              as_s, c1_s, c3_s;
    logic              aligned;
    dstate_e           st_q;

    assign raw_vec = {~as_ni, c1_i, c3_i};

    dtack_sync #(
        .W      (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_vec),
        .q_o    (syn_vec)
    );

    assign {as_s, c1_s, c3_s} = syn_vec;

    dtack_phase_cls u_cls (
        .c1_s_i    (c1_s),
        .c3_s_i    (c3_s),
        .aligned_o (aligned)
    );

    dtack_fsm #(
        .NORM_TICKS (NORM_TICKS)
    ) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .as_s_i     (as_s),
        .as_raw_ni  (as_ni),
        .chip_sel_i (chip_sel_i),
        .aligned_i  (aligned),
        .xrdy_i     (xrdy_i),
        .st_o       (st_q),
        .dtack_no   (dtack_no)
    );

    // Override releases the line at once, without a clock
    assign dtack_oe_o = ovr_ni;

endmodule

// File: rtl/dtack_phase_chk.sv
module dtack_phase_chk
    import dtack_pkg::*;
(
    input logic    clk_i,
    input logic    rst_ni,
    input logic    as_ni,
    input logic    xrdy_i,
    input logic    dtack_no,
    input logic    c1_s,
    input logic    c3_s,
    input dstate_e st_q
);

    AST_ACK_ONLY_IN_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dtack_no |-> (st_q == ST_ACK));                                  // R2

    AST_ALIGN_WAITS_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_COUNT && $past(st_q) == ST_ALIGN) |-> (!$past(c1_s) && !$past(c3_s))); // R4

    AST_NO_ACK_WITHOUT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dtack_no |-> $past(xrdy_i));                                     // R5

    AST_RELEASE_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        as_ni |=> dtack_no);                                              // R7

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_IDLE) |-> dtack_no);                                  // R8

endmodule

bind dtack_phase_gen dtack_phase_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .as_ni    (as_ni),
    .xrdy_i   (xrdy_i),
    .dtack_no (dtack_no),
    .c1_s     (c1_s),
    .c3_s     (c3_s),
    .st_q     (st_q)
);

// File: tb/dtack_phase_gen_tb.sv
module dtack_phase_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NORM_TICKS = 4;
    localparam int QTR        = 3;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic as_ni = 1'b1;
    logic chip_sel = 1'b0;
    logic c1 = 1'b1;
    logic c3 = 1'b0;
    logic xrdy = 1'b1;
    logic ovr_ni = 1'b1;
    logic dtack_n;
    logic dtack_oe;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int exp_q[$];
    logic prev_dtack = 1'b1;

    dtack_phase_gen #(
        .NORM_TICKS  (NORM_TICKS),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_ni),
        .as_ni      (as_ni),
        .chip_sel_i (chip_sel),
        .c1_i       (c1),
        .c3_i       (c3),
        .xrdy_i     (xrdy),
        .ovr_ni     (ovr_ni),
        .dtack_no   (dtack_n),
        .dtack_oe_o (dtack_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Phase pair seen at edge n: (1,0) (1,1) (0,1) (0,0), QTR edges each
    function automatic logic [1:0] ph_at(int n);
        case ((n / QTR) % 4)
            0:       ph_at = 2'b10;
            1:       ph_at = 2'b11;
            2:       ph_at = 2'b01;
            default: ph_at = 2'b00;
        endcase
    endfunction

    always @(negedge clk) {c1, c3} = ph_at(cyc + 1);

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic int exp_edge(int e1, bit chip);
        int j;
        if (!chip || ph_at(e1) == 2'b00) return e1 + 1 + NORM_TICKS;
        j = e1 + 1;
        while (ph_at(j) != 2'b00) j++;
        return j + 1 + NORM_TICKS;
    endfunction

    // Monitor: scores every falling edge of the acknowledge
    always @(negedge clk) begin
        if (rst_ni) begin
            if (prev_dtack && !dtack_n) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected acknowledge", cyc, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(cyc == e, "R2/R3/R4/R5 acknowledge edge", cyc, e);
                end
            end
            prev_dtack = dtack_n;
        end
    end

    task automatic wait_start(int qidx, int off);
        @(negedge clk);
        while ((((cyc + 1) / QTR) % 4) != qidx || ((cyc + 1) % QTR) != off) @(negedge clk);
    endtask

    // Driver: called at a negedge; starts an access and pushes its expected edge
    task automatic run_access(bit chip, int xrdy_late, string req);
        int e1;
        int ex;
        chip_sel = chip;
        as_ni = 1'b0;
        e1 = cyc + 1;
        ex = exp_edge(e1, chip);
        if (xrdy_late > 0) begin
            xrdy = 1'b0;
            ex = ex + xrdy_late;
        end
        exp_q.push_back(ex);
        if (xrdy_late > 0) begin
            while (cyc < ex - 1) @(negedge clk);
            check(dtack_n == 1'b1, "R5 held while not ready", dtack_n, 1);
            xrdy = 1'b1;
        end
        while (cyc < ex + 2) @(negedge clk);
        as_ni = 1'b1;
        @(negedge clk);
        check(dtack_n == 1'b1, "R7 release after strobe", dtack_n, 1);
        check(exp_q.size() == 0, {req, " acknowledge seen"}, exp_q.size(), 0);
        exp_q.delete();
        repeat (4) @(negedge clk);
        chip_sel = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(dtack_n == 1'b1, "R1 acknowledge idle in reset", dtack_n, 1);
        rst_ni = 1'b1;
        @(negedge clk);
        check(dtack_n == 1'b1, "R1 acknowledge idle after reset", dtack_n, 1);
        check(dtack_oe == 1'b1, "R1 enable after reset", dtack_oe, 1);

        // R2 and R4: sweep every start offset of the slot, shared memory
        for (int q = 0; q < 4; q++) begin
            for (int o = 0; o < QTR; o++) begin
                wait_start(q, o);
                run_access(1'b1, 0, (q == 3) ? "R2" : "R4");
            end
        end

        // R3: outside the shared region, phase has no effect
        for (int q = 0; q < 4; q++) begin
            wait_start(q, 1);
            run_access(1'b0, 0, "R3");
        end

        // R5: ready hold-off overlapping an in-sync and a realigned cycle
        wait_start(3, 0);
        run_access(1'b1, 3, "R5");
        wait_start(1, 0);
        run_access(1'b1, 2, "R5");

        // R6: override releases the enable without a clock
        @(negedge clk);
        ovr_ni = 1'b0;
        #1;
        check(dtack_oe == 1'b0, "R6 override drops enable", dtack_oe, 0);
        ovr_ni = 1'b1;
        #1;
        check(dtack_oe == 1'b1, "R6 enable restored", dtack_oe, 1);

        // R8: strobe withdrawn while waiting for the slot
        begin
            bit seen_low;
            seen_low = 1'b0;
            wait_start(0, 0);
            chip_sel = 1'b1;
            as_ni = 1'b0;
            repeat (3) @(negedge clk);
            as_ni = 1'b1;
            for (int k = 0; k < 16; k++) begin
                @(negedge clk);
                if (!dtack_n) seen_low = 1'b1;
            end
            check(!seen_low, "R8 no acknowledge after abort", seen_low, 0);
            chip_sel = 1'b0;
        end
        wait_start(2, 1);
        run_access(1'b1, 0, "R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule